// File: doc/BRIEF.md
# MESI Line State Tracker

This block holds the two-bit coherence state of every line of a write-back cache and moves each state through the four-state MESI protocol. Each clock it can take one event aimed at one line. There are four event kinds: a local read, a local write, a snooped remote read and a snooped invalidate. Each event updates the state of the addressed line in a single cycle. Some transitions need an outside party to finish first. A write to a shared line needs ownership before it can proceed. A snoop that hits a modified line needs its dirty data flushed before the line is given up.

For those two cases the tracker raises a request, holds the line in its old state, and refuses further events until the matching acknowledge arrives. Data storage, bus arbitration and the memory transfer belong to the surrounding cache. A lookup port returns the current state of any line, together with a flag that says whether a local write may go ahead on that line.

Top module: `mesi_line_tracker`

## Requirements
- R1: Line states use the encoding Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. After reset every line reads Invalid, and `busy`, `upg_req`, `wb_req` and `miss` are all low.
- R2: An accepted local read (`ev_op`=2'b00) to an Invalid line fills it. The line goes to Exclusive when `shared_in` is low and to Shared when it is high, and `miss` pulses high for one cycle after the event. A read that hits a valid line leaves its state alone, ignores `shared_in` and keeps `miss` low.
- R3: An accepted local write (`ev_op`=2'b01) to an Invalid line allocates it directly as Modified and pulses `miss`.
- R4: A local write to an Exclusive line moves it to Modified in one cycle, with no request and no miss. A local write to a Modified line leaves it Modified.
- R5: A local write to a Shared line raises `upg_req` and `busy` and leaves the line Shared. The line becomes Modified on the clock edge where `upg_ack` is sampled high, and at that edge `upg_req` and `busy` drop.
- R6: A snooped invalidate (`ev_op`=2'b11) moves a Shared or Exclusive line to Invalid in one cycle. An Invalid line stays Invalid.
- R7: A snooped read (`ev_op`=2'b10) moves an Exclusive line to Shared without raising `wb_req`. Shared and Invalid lines are unchanged.
- R8: A snooped read or invalidate that hits a Modified line raises `wb_req` and `busy`. The line stays Modified while `wb_ack` is low. On the edge where `wb_ack` is high, the line becomes Shared after a snooped read or Invalid after a snooped invalidate, and `wb_req` drops.
- R9: While `busy` is high, events on the event port change no line state. An acknowledge that does not match the pending request (`wb_ack` during an upgrade, for example) is also ignored.
- R10: `look_state` shows the current state of line `look_line`, and `look_wr_ok` is high exactly when that state is Exclusive or Modified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_op | input | 2 | Event kind: 00 local read, 01 local write, 10 snoop read, 11 snoop invalidate |
| ev_line | input | IDXW | Line index the event addresses |
| shared_in | input | 1 | Another cache holds the line; picks Shared instead of Exclusive on a read fill |
| upg_ack | input | 1 | Ownership granted for the pending upgrade |
| wb_ack | input | 1 | Write-back of the pending modified line is done |
| look_line | input | IDXW | Line index to look up |
| look_state | output | 2 | Current state of `look_line` |
| look_wr_ok | output | 1 | Local write permitted on `look_line` |
| busy | output | 1 | A request is pending; events are not accepted |
| upg_req | output | 1 | Ownership upgrade requested for a Shared line |
| wb_req | output | 1 | Write-back requested for a Modified line |
| miss | output | 1 | One-cycle pulse after a local access that found the line Invalid |

## Verification
The checker watches the event-to-state rules on every cycle. A write to an Exclusive line must reach Modified, a write to a Shared line must stall in Shared behind `upg_req`, an invalidate must clear a clean line, and a snoop that hits a Modified line must raise `wb_req`. Both requests must hold until their own acknowledge arrives. Some behaviour only the bench scenarios can show. That includes the choice between Shared and Exclusive on a fill, and the end state after each kind of write-back. It also includes events and mismatched acknowledges that arrive while busy and must be dropped, and the `miss` pulse timing.

// File: rtl/mesi_line_tracker.sv
module mesi_line_tracker #(
  parameter int LINES = 16,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [1:0]      ev_op,
  input  logic [IDXW-1:0] ev_line,
  input  logic            shared_in,
  input  logic            upg_ack,
  input  logic            wb_ack,
  input  logic [IDXW-1:0] look_line,
  output logic [1:0]      look_state,
  output logic            look_wr_ok,
  output logic            busy,
  output logic            upg_req,
  output logic            wb_req,
  output logic            miss
);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [1:0] OP_LRD = 2'b00, OP_LWR = 2'b01, OP_SRD = 2'b10, OP_SINV = 2'b11;
  localparam logic [1:0] PD_NONE = 2'b00, PD_UPG = 2'b01, PD_WBS = 2'b10, PD_WBI = 2'b11;

  logic [LINES-1:0][1:0] st_q;
  logic [1:0]            pend_q;
  logic [IDXW-1:0]       pend_line_q;
  logic                  miss_q;

  logic       acc;
  logic [1:0] cur_st, nxt_st, nxt_pend;
  logic       nxt_miss;

  assign acc    = ev_valid && (pend_q == PD_NONE);
  assign cur_st = st_q[ev_line];

  always_comb begin
    nxt_st   = cur_st;
    nxt_pend = PD_NONE;
    nxt_miss = 1'b0;
    unique case (ev_op)
      OP_LRD: if (cur_st == ST_I) begin
        nxt_st   = shared_in ? ST_S : ST_E;
        nxt_miss = 1'b1;
      end
      OP_LWR: unique case (cur_st)
        ST_I: begin nxt_st = ST_M; nxt_miss = 1'b1; end
        ST_S: nxt_pend = PD_UPG;
        ST_E: nxt_st = ST_M;
        default: ;
      endcase
      OP_SRD: unique case (cur_st)
        ST_M: nxt_pend = PD_WBS;
        ST_E: nxt_st = ST_S;
        default: ;
      endcase
      OP_SINV: unique case (cur_st)
        ST_M: nxt_pend = PD_WBI;
        ST_S, ST_E: nxt_st = ST_I;
        default: ;
      endcase
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= '0;
      pend_q      <= PD_NONE;
      pend_line_q <= '0;
      miss_q      <= 1'b0;
    end else begin
      miss_q <= acc && nxt_miss;
      if (acc) begin
        st_q[ev_line] <= nxt_st;
        if (nxt_pend != PD_NONE) begin
          pend_q      <= nxt_pend;
          pend_line_q <= ev_line;
        end
      end else begin
        unique case (pend_q)
          PD_UPG: if (upg_ack) begin st_q[pend_line_q] <= ST_M; pend_q <= PD_NONE; end
          PD_WBS: if (wb_ack)  begin st_q[pend_line_q] <= ST_S; pend_q <= PD_NONE; end
          PD_WBI: if (wb_ack)  begin st_q[pend_line_q] <= ST_I; pend_q <= PD_NONE; end
          default: ;
        endcase
      end
    end
  end

  assign look_state = st_q[look_line];
  assign look_wr_ok = look_state[1];
  assign busy       = (pend_q != PD_NONE);
  assign upg_req    = (pend_q == PD_UPG);
  assign wb_req     = pend_q[1];
  assign miss       = miss_q;
endmodule

// File: rtl/mesi_line_tracker_chk.sv
module mesi_line_tracker_chk #(
  parameter int LINES = 16,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ev_valid,
  input logic [1:0]            ev_op,
  input logic [IDXW-1:0]       ev_line,
  input logic                  upg_ack,
  input logic                  wb_ack,
  input logic                  busy,
  input logic                  upg_req,
  input logic                  wb_req,
  input logic [LINES-1:0][1:0] st_q
);
  logic ok;
  assign ok = rst_n && ev_valid && !busy;

  a_r4_excl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ok && ev_op == 2'b01 && st_q[ev_line] == 2'b10 |=> st_q[$past(ev_line)] == 2'b11);

  a_r5_shared_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ok && ev_op == 2'b01 && st_q[ev_line] == 2'b01 |=> upg_req && st_q[$past(ev_line)] == 2'b01);

  a_r5_upg_held: assert property (@(posedge clk) disable iff (!rst_n)
    upg_req && !upg_ack |=> upg_req);

  a_r6_inval_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ok && ev_op == 2'b11 && (st_q[ev_line] == 2'b01 || st_q[ev_line] == 2'b10)
    |=> st_q[$past(ev_line)] == 2'b00);

  a_r8_snoop_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    ok && ev_op[1] && st_q[ev_line] == 2'b11 |=> wb_req);

  a_r8_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req);
endmodule

bind mesi_line_tracker mesi_line_tracker_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_line(ev_line),
  .upg_ack(upg_ack), .wb_ack(wb_ack), .busy(busy), .upg_req(upg_req),
  .wb_req(wb_req), .st_q(st_q)
);

// File: tb/mesi_line_tracker_tb_top.sv
`timescale 1ns/1ps
module mesi_line_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, shared_in = 1'b0, upg_ack = 1'b0, wb_ack = 1'b0;
  logic [1:0] ev_op = 2'b00;
  logic [3:0] ev_line = '0, look_line = '0;
  logic [1:0] look_state;
  logic look_wr_ok, busy, upg_req, wb_req, miss;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  mesi_line_tracker #(.LINES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_line(ev_line),
    .shared_in(shared_in), .upg_ack(upg_ack), .wb_ack(wb_ack), .look_line(look_line),
    .look_state(look_state), .look_wr_ok(look_wr_ok), .busy(busy),
    .upg_req(upg_req), .wb_req(wb_req), .miss(miss));

  // {op[9:8], line[7:4], shared_in[3], expected state[2:1], expected miss[0]}
  localparam int NV = 15;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 4'd1, 1'b0, 2'd2, 1'b1},  // R2 fill, not shared -> E
    {2'd0, 4'd2, 1'b1, 2'd1, 1'b1},  // R2 fill, shared -> S
    {2'd1, 4'd3, 1'b0, 2'd3, 1'b1},  // R3 write miss -> M
    {2'd1, 4'd1, 1'b0, 2'd3, 1'b0},  // R4 E -> M
    {2'd0, 4'd1, 1'b1, 2'd3, 1'b0},  // R2 read hit on M
    {2'd2, 4'd2, 1'b0, 2'd1, 1'b0},  // R7 snoop read on S
    {2'd0, 4'd4, 1'b0, 2'd2, 1'b1},  // R2
    {2'd2, 4'd4, 1'b0, 2'd1, 1'b0},  // R7 E -> S
    {2'd3, 4'd4, 1'b0, 2'd0, 1'b0},  // R6 S -> I
    {2'd3, 4'd5, 1'b0, 2'd0, 1'b0},  // R6 I stays I
    {2'd0, 4'd6, 1'b1, 2'd1, 1'b1},  // R2
    {2'd3, 4'd6, 1'b0, 2'd0, 1'b0},  // R6 S -> I
    {2'd0, 4'd7, 1'b0, 2'd2, 1'b1},  // R2
    {2'd3, 4'd7, 1'b0, 2'd0, 1'b0},  // R6 E -> I
    {2'd0, 4'd2, 1'b0, 2'd1, 1'b0}   // R2 hit on S ignores shared_in
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [3:0] line, input logic sh);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = op; ev_line = line; shared_in = sh; look_line = line;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic pulse_ack(input logic up, input logic wb);
    @(negedge clk);
    upg_ack = up; wb_ack = wb;
    @(negedge clk);
    upg_ack = 1'b0; wb_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      look_line = i[3:0];
      #0.1 check("R1 reset state", look_state, 0);
    end
    check("R1 reset busy", busy, 0);
    check("R1 reset requests", {upg_req, wb_req, miss}, 0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][9:8], VEC[v][7:4], VEC[v][3]);
      check($sformatf("R2-R7 vector %0d state", v), look_state, VEC[v][2:1]);
      check($sformatf("R2 R3 vector %0d miss", v), miss, VEC[v][0]);
    end
    // lines now: 1=M, 2=S, 3=M
    look_line = 4'd2;
    #0.1 check("R10 wr_ok on S", look_wr_ok, 0);

    // R5 upgrade handshake
    send(2'd1, 4'd2, 1'b0);
    check("R5 upg_req raised", {upg_req, busy}, 3);
    check("R5 still S", look_state, 1);
    // R9 event while busy is dropped
    send(2'd3, 4'd1, 1'b0);
    check("R9 busy event ignored", look_state, 3);
    check("R9 no wb_req", wb_req, 0);
    pulse_ack(1'b0, 1'b1);
    look_line = 4'd2;
    #0.1 check("R9 wrong ack ignored", {upg_req, look_state}, 3'b101);
    pulse_ack(1'b1, 1'b0);
    check("R5 upgraded to M", look_state, 3);
    check("R5 upg_req dropped", {upg_req, busy}, 0);

    // R8 snoop read on M with write-back
    send(2'd2, 4'd3, 1'b0);
    check("R8 wb_req raised", {wb_req, busy}, 3);
    check("R10 wr_ok on M", look_wr_ok, 1);
    repeat (3) @(negedge clk);
    check("R8 wb_req held", {wb_req, look_state}, 3'b111);
    pulse_ack(1'b0, 1'b1);
    check("R8 read wb ends Shared", look_state, 1);
    check("R8 wb_req dropped", wb_req, 0);
    check("R10 wr_ok after downgrade", look_wr_ok, 0);

    // R8 snoop invalidate on M
    send(2'd3, 4'd1, 1'b0);
    check("R8 inv wb_req", wb_req, 1);
    pulse_ack(1'b0, 1'b1);
    check("R8 inv wb ends Invalid", look_state, 0);
    check("R8 busy cleared", busy, 0);

    // R10 on Exclusive
    send(2'd0, 4'd8, 1'b0);
    check("R10 wr_ok on E", {look_state, look_wr_ok}, 3'b101);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule